// File: doc/BRIEF.md
# Streaming Eight-Point DCT Stage

This block computes a one-dimensional forward discrete cosine transform of length eight on a stream of samples. It is the arithmetic core of a row/column 2-D transform. The same stage serves the row pass, where it takes raw image samples, and the column pass, where it takes values read back from transpose storage. Samples arrive one per accepted beat in groups of eight. Each accepted sample drives eight parallel multiply-accumulate lanes. Each lane takes its cosine weight from a computed table indexed by the lane's frequency and the sample's position in the group.

When the eighth sample of a group is accepted, the eight rounded and saturated sums are copied into a holding shifter. The accumulators restart with the next sample. The holding shifter emits the coefficients in frequency order, lowest first. A parameter selects two's-complement input, or unsigned input with a zero-level shift applied before the arithmetic.

Both stream edges use valid/ready. A beat moves when valid and ready are both high at a rising clock edge. On the output side the block holds `out_valid` and `out_data` steady until the consumer accepts the beat. On the input side `in_ready` drops only for a sample that would complete a group while the holding shifter still has more than one coefficient left to deliver, or has exactly one left and `out_ready` is low. Every other sample is accepted whatever the output is doing.

Top module: `dct8_serial_stage`

## Requirements
- R1: For every group of eight accepted samples v(0..7), the block delivers exactly eight output beats in the order u=0..7. Each beat carries X(u)=½·C(u)·Σ v(n)·cos((2n+1)uπ/16), where C(0)=1/√2 and C(u)=1 otherwise, scaled by 2^OUT_FRAC and within ±1 LSB.
- R2: With SIGNED_IN=0, an input code is treated as unsigned and has 2^(IN_W-1) subtracted from it, so for IN_W=8 the code 0 becomes -128 and 255 becomes 127. With SIGNED_IN=1, the code is read as two's complement.
- R3: Each output is rounded to the nearest step of 2^-OUT_FRAC and clamped to the signed range of OUT_W bits. For OUT_W=10 that range is -512..511.
- R4: A sample accepted with `in_first` high becomes position 0 of a new group. Any samples accepted since the last completed group are discarded.
- R5: While `out_ready` stays high, `in_ready` never drops, so groups follow one another with no idle cycle. When the holding shifter is empty, the first coefficient of a group is valid in the cycle after its eighth sample is accepted.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged into the next cycle.
- R7: No coefficient is ever overwritten. A group is completed only when the holding shifter is empty, or holds one coefficient that leaves in the same cycle.
- R8: After reset, `out_valid` is low, `in_ready` is high, and the next sample is taken as position 0.
- R9: Cycles with `in_valid` low change neither the accumulated sums nor the group position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage will take the sample this cycle |
| in_first | input | 1 | Sample is position 0 of a group |
| in_sample | input | IN_W | Input sample code |
| out_valid | output | 1 | Coefficient present on out_data |
| out_ready | input | 1 | Consumer takes the coefficient this cycle |
| out_data | output | OUT_W | Signed coefficient with OUT_FRAC fraction bits |

## Verification
The bench builds two copies with IN_W=8, OUT_W=10 and OUT_FRAC=1, one unsigned and one signed, and drives both from the same stimulus. The narrow output with one fraction bit brings clamping at both ends of the range within reach of ordinary constant inputs. It also keeps the fixed-point error inside the ±1 LSB tolerance. The small input width makes an exhaustive sweep possible: every input code is placed at every group position, and each result is checked in both input formats. Random stalls on the output together with random input gaps then exercise the hold and no-overwrite rules.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 11;
  localparam int NPTS      = 8;

  // 0.5*C(u)*cos((2n+1)u*pi/16) in Q1.11, folded from one quarter wave
  function automatic int dct8_coef(int u, int n);
    int m;
    int mag;
    bit neg;
    if (u == 0) return 724;
    m = ((2 * n + 1) * u) % 32;
    if (m > 16) m = 32 - m;
    neg = 1'b0;
    if (m > 8) begin
      m   = 16 - m;
      neg = 1'b1;
    end
    case (m)
      0: mag = 1024;
      1: mag = 1004;
      2: mag = 946;
      3: mag = 851;
      4: mag = 724;
      5: mag = 569;
      6: mag = 392;
      7: mag = 200;
      default: mag = 0;
    endcase
    return neg ? -mag : mag;
  endfunction
endpackage

// File: rtl/dct8_level_shift.sv
module dct8_level_shift #(
  parameter int IN_W      = 8,
  parameter bit SIGNED_IN = 1'b0
) (
  input  logic [IN_W-1:0]        code_i,
  output logic signed [IN_W-1:0] val_o
);
  generate
    if (SIGNED_IN) begin : g_signed
      assign val_o = $signed(code_i);
    end else begin : g_unsigned
      // subtracting half range equals inverting the top bit
      assign val_o = $signed({~code_i[IN_W-1], code_i[IN_W-2:0]});
    end
  endgenerate
endmodule

// File: rtl/dct8_mac_lane.sv
module dct8_mac_lane
  import dct8_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int FREQ  = 0,
  parameter int ACC_W = IN_W + COEF_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    restart_i,
  input  logic [2:0]              pos_i,
  input  logic signed [IN_W-1:0]  x_i,
  output logic signed [ACC_W-1:0] sum_o
);
  localparam int PROD_W = IN_W + COEF_W;

  logic signed [COEF_W-1:0] coef;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;

  always_comb coef = COEF_W'(dct8_coef(FREQ, int'(pos_i)));
  assign prod  = x_i * coef;
  assign sum_o = (restart_i ? '0 : acc) + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (en_i) acc <= sum_o;
  end
endmodule

// File: rtl/dct8_round_sat.sv
module dct8_round_sat #(
  parameter int IN_W  = 23,
  parameter int OUT_W = 16,
  parameter int SHIFT = 11
) (
  input  logic signed [IN_W-1:0] d_i,
  output logic [OUT_W-1:0]       q_o
);
  localparam int W = IN_W + 1;

  logic signed [W-1:0] ext, q, maxv, minv;

  assign ext  = {d_i[IN_W-1], d_i};
  assign maxv = {{(W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  assign minv = {{(W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  generate
    if (SHIFT > 0) begin : g_round
      logic signed [W-1:0] half;
      assign half = {{(W-1){1'b0}}, 1'b1} <<< (SHIFT - 1);
      assign q    = (ext + half) >>> SHIFT;
    end else begin : g_pass
      assign q = ext;
    end
  endgenerate

  always_comb begin
    if (q > maxv)      q_o = maxv[OUT_W-1:0];
    else if (q < minv) q_o = minv[OUT_W-1:0];
    else               q_o = q[OUT_W-1:0];
  end
endmodule

// File: rtl/dct8_out_buf.sv
module dct8_out_buf #(
  parameter int N     = 8,
  parameter int OUT_W = 16,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [N-1:0][OUT_W-1:0]  load_data_i,
  input  logic                     pop_i,
  output logic                     valid_o,
  output logic [OUT_W-1:0]         data_o,
  output logic [CNT_W-1:0]         cnt_o
);
  logic [N-1:0][OUT_W-1:0] hold;
  logic [CNT_W-1:0]        cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
    end else if (load_i) begin
      cnt  <= CNT_W'(N);
      hold <= load_data_i;
    end else if (pop_i) begin
      cnt <= cnt - 1'b1;
      for (int i = 0; i < N - 1; i++) hold[i] <= hold[i+1];
      hold[N-1] <= '0;
    end
  end

  assign valid_o = (cnt != '0);
  assign data_o  = hold[0];
  assign cnt_o   = cnt;
endmodule

// File: rtl/dct8_serial_stage.sv
module dct8_serial_stage
  import dct8_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 16,
  parameter int OUT_FRAC  = 0,
  parameter bit SIGNED_IN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_first,
  input  logic [IN_W-1:0]  in_sample,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int POS_W = $clog2(NPTS);
  localparam int ACC_W = IN_W + COEF_W + POS_W;
  localparam int SHIFT = COEF_FRAC - OUT_FRAC;
  localparam int CNT_W = $clog2(NPTS + 1);

  logic [POS_W-1:0]           pos, eff_pos;
  logic                       fire, restart, done, pop;
  logic signed [IN_W-1:0]     x;
  logic [CNT_W-1:0]           cnt;
  logic [NPTS-1:0][OUT_W-1:0] rounded;

  assign fire    = in_valid && in_ready;
  assign eff_pos = in_first ? '0 : pos;
  assign restart = (eff_pos == '0);
  assign done    = fire && (eff_pos == POS_W'(NPTS - 1));
  assign pop     = out_valid && out_ready;
  // only a completing sample needs room in the holding shifter
  assign in_ready = (pos != POS_W'(NPTS - 1)) || (cnt == '0) ||
                    ((cnt == CNT_W'(1)) && out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (fire) pos <= eff_pos + 1'b1;
  end

  dct8_level_shift #(.IN_W(IN_W), .SIGNED_IN(SIGNED_IN)) u_shift (
    .code_i (in_sample),
    .val_o  (x)
  );

  for (genvar u = 0; u < NPTS; u++) begin : g_lane
    logic signed [ACC_W-1:0] sum;

    dct8_mac_lane #(.IN_W(IN_W), .FREQ(u), .ACC_W(ACC_W)) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (fire),
      .restart_i (restart),
      .pos_i     (eff_pos),
      .x_i       (x),
      .sum_o     (sum)
    );

    dct8_round_sat #(.IN_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_rs (
      .d_i (sum),
      .q_o (rounded[u])
    );
  end

  dct8_out_buf #(.N(NPTS), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_obuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (done),
    .load_data_i (rounded),
    .pop_i       (pop),
    .valid_o     (out_valid),
    .data_o      (out_data),
    .cnt_o       (cnt)
  );
endmodule

// File: rtl/dct8_serial_stage_chk.sv
module dct8_serial_stage_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_first,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data
);
  logic [2:0] mpos;
  logic [4:0] pending;
  logic       acc_beat, grp_done, out_beat;

  assign acc_beat = in_valid && in_ready;
  assign grp_done = acc_beat && !in_first && (mpos == 3'd7);
  assign out_beat = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mpos    <= 3'd0;
      pending <= 5'd0;
    end else begin
      if (acc_beat) mpos <= in_first ? 3'd1 : mpos + 3'd1;
      pending <= pending + (grp_done ? 5'd8 : 5'd0) - (out_beat ? 5'd1 : 5'd0);
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= 5'd8); // R7
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (pending != 5'd0)); // R1
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R5
  AST_READY_MID_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (mpos != 3'd7) |-> in_ready); // R7
endmodule

bind dct8_serial_stage dct8_serial_stage_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_first  (in_first),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/dct8_serial_stage_tb.sv
module dct8_serial_stage_tb;
  localparam int  IN_W     = 8;
  localparam int  OUT_W    = 10;
  localparam int  OUT_FRAC = 1;
  localparam real SCALE    = 2.0;
  localparam real PI       = 3.14159265358979323846;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_first = 1'b0;
  logic [IN_W-1:0]  in_sample = '0;
  logic             out_ready = 1'b1;
  logic             in_ready, in_ready_s;
  logic             out_valid, out_valid_s;
  logic [OUT_W-1:0] out_data, out_data_s;

  int    n_chk = 0, n_fail = 0;
  real   exp_u[$], exp_s[$];
  int    grp[8];
  int    gpos = 0;
  bit    rand_ready = 1'b0;
  bit    cont_mode = 1'b0;
  int    noready_cnt = 0;
  string cur_tag = "R1 setup";
  bit    stall_u = 1'b0, stall_s = 1'b0;
  logic [OUT_W-1:0] prev_u, prev_s;

  always #2 clk = ~clk;

  dct8_serial_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .SIGNED_IN(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_sample(in_sample), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  dct8_serial_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .SIGNED_IN(1'b1)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_s),
    .in_first(in_first), .in_sample(in_sample), .out_valid(out_valid_s),
    .out_ready(out_ready), .out_data(out_data_s));

  task automatic chk(bit ok, string tag, real act, real expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic real clampr(real v);
    real hi, lo;
    hi = real'((1 << (OUT_W - 1)) - 1);
    lo = -real'(1 << (OUT_W - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // expected coefficients for both input formats, from the transform formula
  function automatic void push_group();
    for (int u = 0; u < 8; u++) begin
      real su, ss, c, cu;
      su = 0.0;
      ss = 0.0;
      for (int n = 0; n < 8; n++) begin
        c  = $cos(real'((2 * n + 1) * u) * PI / 16.0);
        su = su + real'(grp[n] - 128) * c;
        ss = ss + real'(grp[n] > 127 ? grp[n] - 256 : grp[n]) * c;
      end
      cu = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
      exp_u.push_back(clampr(0.5 * cu * su * SCALE));
      exp_s.push_back(clampr(0.5 * cu * ss * SCALE));
    end
  endfunction

  // entered and left at 1 ns after a rising edge
  task automatic send(int code, bit first, int gaps);
    bit ok;
    in_valid = 1'b0;
    repeat (gaps) begin @(posedge clk); #1; end
    in_valid  = 1'b1;
    in_sample = IN_W'(code);
    in_first  = first;
    do begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk);
      #1;
    end while (!ok);
    in_valid = 1'b0;
    in_first = 1'b0;
    if (first) gpos = 0;
    grp[gpos] = code;
    if (gpos == 7) push_group();
    gpos = (gpos + 1) % 8;
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = rand_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      real a, e;
      if (stall_u) chk(out_valid && out_data == prev_u, "R6 hold unsigned",
                       real'($signed(out_data)), real'($signed(prev_u)));
      if (stall_s) chk(out_valid_s && out_data_s == prev_s, "R6 hold signed",
                       real'($signed(out_data_s)), real'($signed(prev_s)));
      if (out_valid && out_ready) begin
        a = real'($signed(out_data));
        if (exp_u.size() == 0) chk(1'b0, "R1 unexpected beat unsigned", a, 0.0);
        else begin
          e = exp_u.pop_front();
          chk((a - e <= 1.0) && (e - a <= 1.0), {cur_tag, " unsigned R2"}, a, e);
        end
      end
      if (out_valid_s && out_ready) begin
        a = real'($signed(out_data_s));
        if (exp_s.size() == 0) chk(1'b0, "R1 unexpected beat signed", a, 0.0);
        else begin
          e = exp_s.pop_front();
          chk((a - e <= 1.0) && (e - a <= 1.0), {cur_tag, " signed R2"}, a, e);
        end
      end
      stall_u = out_valid && !out_ready;
      stall_s = out_valid_s && !out_ready;
      prev_u  = out_data;
      prev_s  = out_data_s;
      if (cont_mode && !(in_ready && in_ready_s)) noready_cnt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0.0, 1.0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !out_valid_s, "R8 out_valid after reset", real'(out_valid), 0.0);
    chk(in_ready && in_ready_s, "R8 in_ready after reset", real'(in_ready), 1.0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // latency into an empty holding shifter; first sample without in_first (R8)
    cur_tag = "R1 ramp";
    for (int n = 0; n < 8; n++) send(n * 20, 1'b0, 0);
    @(negedge clk);
    chk(out_valid && out_valid_s, "R5 first coefficient next cycle", real'(out_valid), 1.0);
    @(posedge clk); #1;
    repeat (10) begin @(posedge clk); #1; end

    // every code at every position, back to back
    cur_tag = "R1 impulse sweep";
    cont_mode = 1'b1;
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 256; c++)
        for (int n = 0; n < 8; n++) send(n == p ? c : 128, n == 0, 0);
    cont_mode = 1'b0;
    chk(noready_cnt == 0, "R5 in_ready low during continuous run", real'(noready_cnt), 0.0);

    cur_tag = "R3 saturation";
    for (int n = 0; n < 8; n++) send(255, 1'b0, 0);
    for (int n = 0; n < 8; n++) send(0, 1'b0, 0);
    for (int n = 0; n < 8; n++) send(127, 1'b0, 0);
    for (int n = 0; n < 8; n++) send(128, 1'b0, 0);
    for (int n = 0; n < 8; n++) send(n[0] ? 255 : 0, 1'b0, 0);

    cur_tag = "R4 restart";
    for (int n = 0; n < 5; n++) send(255, 1'b0, 0);
    for (int n = 0; n < 8; n++) send(100 + n * 3, n == 0, 0);
    for (int n = 0; n < 3; n++) send(0, 1'b0, 0);
    for (int n = 0; n < 8; n++) send(200 - n * 7, n == 0, 1);

    cur_tag = "R7 backpressure R9 gaps";
    rand_ready = 1'b1;
    for (int g = 0; g < 300; g++)
      for (int n = 0; n < 8; n++)
        send($urandom_range(0, 255), n == 0, $urandom_range(0, 2));
    rand_ready = 1'b0;

    repeat (200) begin
      @(posedge clk); #1;
      if (exp_u.size() == 0 && exp_s.size() == 0) break;
    end
    repeat (4) @(posedge clk);
    chk(exp_u.size() == 0 && exp_s.size() == 0, "R7 all coefficients delivered",
        real'(exp_u.size() + exp_s.size()), 0.0);
    finish_run();
  end
endmodule